// File: doc/BRIEF.md
# Encoded-Ratio System Clock Divider

This block takes one fast PLL-domain clock and produces four synchronous clock-enable streams: core, high-speed bus, low-speed bus and memory. Each stream has a 4-bit ratio code in a shared 32-bit control word. The code picks a divide value from a fixed table that mixes powers of two with multiples of three. Each stream then asserts its enable for one PLL cycle in every divide period. A divide value of 1 holds the enable high.

New ratio codes take effect only when the change-enable bit of the control word is set. They are applied on a common boundary, where every stream's counter is at terminal count together, so no period is ever cut short. A further bit selects the pace of a half-rate PLL enable: it is either asserted every cycle or every other cycle. The control word is written and read back through a plain write-strobe and read-data port.

Top module: `sysclk_ratio_div`

## Requirements
- R1: Ratio codes 0,1,2,3,4,5,6,7,8,9 select divide values 1,2,3,4,6,8,12,16,24,32 respectively.
- R2: A ratio code of 10 to 15 divides by 32.
- R3: The control word holds the following ratio fields: core in bits 3:0, high-speed bus in bits 7:4, low-speed bus in bits 11:8 and memory in bits 15:12.
- R4: Each enable output is high for exactly one cycle per divide period. With a divide value of 1 it stays high continuously.
- R5: While bit 22 (change enable) of the control word is 0, newly written ratio codes are not applied and the outputs keep their previous rates.
- R6: New codes are applied only in a cycle where every stream is at terminal count. The pulse in progress therefore completes its full old period before the new period starts.
- R7: Bit 21 of the control word controls `half_en`. When the bit is 1, `half_en` is high on every cycle. When it is 0, `half_en` is high on every other cycle.
- R8: After synchronous reset, all ratio codes are 0, all four enables are high, and `rd_data` reads 0.
- R9: `rd_data` returns the last value written ANDed with 0x0060FFFF, so unimplemented bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word |
| core_en | output | 1 | Core clock enable |
| hbus_en | output | 1 | High-speed bus clock enable |
| lbus_en | output | 1 | Low-speed bus clock enable |
| mem_en | output | 1 | Memory clock enable |
| half_en | output | 1 | Half-rate PLL enable |

## Verification
The assertions check on every cycle that the applied codes change only when the change-enable bit is set and all counters sit at terminal count. They also check that a stream with a divide above 1 never holds its enable high for two cycles, that a divide-by-1 stream stays high, that readback matches the masked write, and that the half-rate enable alternates when bit 21 is clear. The table mapping, the field positions and the exact period lengths can only be shown by the bench scenarios. The bench counts enable pulses over fixed windows and measures the pulse gap across a ratio change made mid-period.

// File: rtl/sysclk_ratio_div.sv
module sysclk_ratio_div #(
  parameter int NSTREAM = 4,
  parameter int CODE_W  = 4,
  parameter int CNT_W   = 5,
  parameter logic [31:0] RD_MASK = 32'h0060_FFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        core_en,
  output logic        hbus_en,
  output logic        lbus_en,
  output logic        mem_en,
  output logic        half_en
);
  localparam int CHG_BIT  = 22;
  localparam int HALF_BIT = 21;

  logic [31:0] ctrl;
  logic [NSTREAM-1:0][CODE_W-1:0] act;
  logic [NSTREAM-1:0][CNT_W-1:0]  cnt;
  logic [NSTREAM-1:0]             term;
  logic half_ph;
  logic apply;

  function automatic logic [CNT_W-1:0] lim_of(input logic [CODE_W-1:0] c);
    case (c)
      4'd0: lim_of = 5'd0;
      4'd1: lim_of = 5'd1;
      4'd2: lim_of = 5'd2;
      4'd3: lim_of = 5'd3;
      4'd4: lim_of = 5'd5;
      4'd5: lim_of = 5'd7;
      4'd6: lim_of = 5'd11;
      4'd7: lim_of = 5'd15;
      4'd8: lim_of = 5'd23;
      default: lim_of = 5'd31;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else if (wr_en) ctrl <= wr_data & RD_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) half_ph <= 1'b0;
    else half_ph <= ~half_ph;
  end

  assign apply   = (&term) && ctrl[CHG_BIT];
  assign rd_data = ctrl;
  assign half_en = ctrl[HALF_BIT] | half_ph;

  for (genvar i = 0; i < NSTREAM; i++) begin : g_strm
    assign term[i] = (cnt[i] == lim_of(act[i]));

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt[i] <= '0;
        act[i] <= '0;
      end else begin
        cnt[i] <= term[i] ? '0 : cnt[i] + 1'b1;
        if (apply) act[i] <= ctrl[i*CODE_W +: CODE_W];
      end
    end

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
      (term[i] && act[i] != '0 && !apply) |=> !term[i]); // R4
    AST_DIV1_STEADY: assert property (@(posedge clk) disable iff (rst)
      (act[i] == '0 && !apply) |=> term[i]); // R1
  end

  assign core_en = term[0];
  assign hbus_en = term[1];
  assign lbus_en = term[2];
  assign mem_en  = term[3];

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (core_en && hbus_en && lbus_en && mem_en && rd_data == 32'd0)); // R8
  AST_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !ctrl[CHG_BIT] |=> $stable(act)); // R5
  AST_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !(&term) |=> $stable(act)); // R6
  AST_READBACK: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data == ($past(wr_data) & RD_MASK)); // R9
  AST_HALF_ALT: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[HALF_BIT] && !wr_en && half_en) |=> !half_en); // R7
endmodule

// File: tb/sysclk_ratio_div_bench.sv
module sysclk_ratio_div_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 192;
  localparam logic [31:0] CHG = 32'h0040_0000;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic core_en, hbus_en, lbus_en, mem_en, half_en;
  int cyc = 0, nchk = 0, nfail = 0;
  bit done = 0;

  sysclk_ratio_div u_sysclk_ratio_div (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .core_en(core_en), .hbus_en(hbus_en), .lbus_en(lbus_en), .mem_en(mem_en),
    .half_en(half_en));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      nfail++; nchk++;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  // codes, expected divide for core/hbus/lbus/mem
  typedef struct packed { logic [15:0] code; int unsigned d0, d1, d2, d3; } vec_t;
  localparam vec_t VT [6] = '{
    '{16'h3210, 1, 2, 3, 4},
    '{16'h7654, 6, 8, 12, 16},
    '{16'hA998, 24, 32, 32, 32},
    '{16'hF0C5, 8, 32, 1, 32},
    '{16'h1234, 6, 4, 3, 2},
    '{16'h0000, 1, 1, 1, 1}};

  task automatic chk(input string req, input longint got, input longint exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk); wr_en = 1; wr_data = w;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic count(output int c0, output int c1, output int c2, output int c3, output int ch);
    c0 = 0; c1 = 0; c2 = 0; c3 = 0; ch = 0;
    for (int k = 0; k < WIN; k++) begin
      @(negedge clk);
      c0 += core_en; c1 += hbus_en; c2 += lbus_en; c3 += mem_en; ch += half_en;
    end
  endtask

  task automatic settle();
    repeat (200) @(negedge clk);
  endtask

  initial begin
    int c0, c1, c2, c3, ch, t0, g;
    repeat (3) @(negedge clk);
    rst = 0;
    // R8 reset state
    chk("R8 core_en", core_en, 1); chk("R8 hbus_en", hbus_en, 1);
    chk("R8 lbus_en", lbus_en, 1); chk("R8 mem_en", mem_en, 1);
    chk("R8 rd_data", rd_data, 0);
    count(c0, c1, c2, c3, ch);
    chk("R4 div1 continuous", c0 + c1 + c2 + c3, 4 * WIN);
    chk("R7 half alternates", ch, WIN / 2);

    // table walk: R1 R2 R3 R4
    foreach (VT[v]) begin
      wr(CHG | VT[v].code);
      settle();
      count(c0, c1, c2, c3, ch);
      chk("R1/R3 core field", c0, WIN / VT[v].d0);
      chk("R1/R3 hbus field", c1, WIN / VT[v].d1);
      chk("R1/R2 lbus field", c2, WIN / VT[v].d2);
      chk("R2/R3 mem field", c3, WIN / VT[v].d3);
    end

    // R5 change enable clear: codes not applied
    wr(32'h0000_3333);
    settle();
    count(c0, c1, c2, c3, ch);
    chk("R5 locked core", c0, WIN); chk("R5 locked mem", c3, WIN);
    wr(CHG | 32'h0000_3333);
    settle();
    count(c0, c1, c2, c3, ch);
    chk("R5 unlocked core", c0, WIN / 4);

    // R6 change mid-period: old period completes, then new one
    wr(CHG | 32'h0000_0009);
    settle();
    while (!core_en) @(negedge clk);
    t0 = cyc;
    repeat (5) @(negedge clk);
    wr(CHG | 32'h0000_0002);
    while (!core_en) @(negedge clk);
    g = cyc - t0; t0 = cyc;
    chk("R6 old period kept", g, 32);
    @(negedge clk);
    while (!core_en) @(negedge clk);
    chk("R6 new period", cyc - t0, 3);

    // R7 full-rate half enable
    wr(32'h0020_0000);
    count(c0, c1, c2, c3, ch);
    chk("R7 half full rate", ch, WIN);

    // R9 readback mask
    wr(32'hFFFF_FFFF);
    @(negedge clk);
    chk("R9 readback mask", rd_data, 32'h0060_FFFF);
    wr(32'h1234_5678);
    chk("R9 readback", rd_data, 32'h0020_5678);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule